// File: doc/BRIEF.md
# Muxed Two-Stage Clock Divider

This block derives a slower clock from one of four reference sources. All four references are modelled as single-cycle enable pulses in one fast system clock domain. The selected reference is first divided by a power of two (1, 2, 4 or 8) and then by an integer from 1 to 32. The block delivers the result in two forms: a one-cycle clock-enable pulse at the start of every divided period, and a square wave.

Software sets the divider through one 32-bit control word. The word is written through a synchronous port with byte strobes and is always visible on a read-data bus. The word has three fields: source select at bits 17:16, power-of-two exponent at bits 5:4, and linear divisor field at bits 12:8. A divisor field value n divides by n+1. Settings that are written into the word are copied into the running divider only when the current output period ends. This means a period is never shortened or mixed.

Top module: `clkdiv_mux`

## Requirements
- R1: While reset is held, rd_data is 0, clk_en is 0 and clk_out is 1. After reset the divider passes source 0 through with a total ratio of 1.
- R2: Bits 17:16 pick which bit of src_tick is counted. The output period scales with the period of the chosen source.
- R3: Bits 5:4 hold an exponent s that divides the selected source by 2^s, with s from 0 to 3.
- R4: Bits 12:8 hold n, which divides by n+1. The interval between clk_en pulses is the source period × 2^s × (n+1) system clocks.
- R5: Each of the three fields reads back on rd_data exactly as written. Every other bit of rd_data always reads 0.
- R6: A write updates only the bytes whose wr_strb bit is set: bit 0 covers bits 7:0, bit 1 covers bits 15:8, bit 2 covers bits 23:16 and bit 3 covers bits 31:24. A write with no strobe set changes nothing.
- R7: A new setting takes effect only at the end of the period in progress. The period during which the write happens keeps the old ratio.
- R8: clk_en is high for exactly one system clock per divided period, whenever the period is longer than one system clock.
- R9: For a total ratio N, clk_out is high for ceil(N/2) source periods and low for floor(N/2) source periods. When N is odd, the high phase is one source period longer than the low phase.
- R10: Every clk_en pulse coincides with clk_out being high, and clk_out rises only in a cycle where clk_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | One enable pulse per reference source |
| wr_en | input | 1 | Control word write strobe |
| wr_strb | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| clk_en | output | 1 | One-cycle pulse at each divided period start |
| clk_out | output | 1 | Divided square wave |

## Verification
The bench measures the pulse interval and the high-phase length for every exponent at divisor values 0, 1, 6 and 31. A design that applies the two stages in the wrong order, or that drops the +1, produces periods that are off by a source period or by a factor of two. An odd ratio such as 7 catches a duty-cycle rounding that falls the wrong way. A write made in the middle of a long period shows whether the setting is applied early, which shortens the period in flight. Partial-strobe writes and a strobe-less write catch field cross-talk and read-only bits that do not read as zero.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int REG_W     = 32;
    localparam int SEL_W     = 2;
    localparam int SHIFT_W   = 2;
    localparam int DIV_W     = 5;
    localparam int SEL_LSB   = 16;
    localparam int SHIFT_LSB = 4;
    localparam int DIV_LSB   = 8;
    localparam int N_SRC     = 1 << SEL_W;
    localparam int PRE_W     = (1 << SHIFT_W) - 1;
    localparam int POS_W     = PRE_W + DIV_W;
    localparam int NBYTE     = REG_W / 8;

    function automatic logic [REG_W-1:0] field_mask(input int lsb, input int w);
        logic [REG_W-1:0] one;
        one = 1;
        return ((one << w) - one) << lsb;
    endfunction

    localparam logic [REG_W-1:0] RW_MASK = field_mask(SEL_LSB, SEL_W)
                                         | field_mask(SHIFT_LSB, SHIFT_W)
                                         | field_mask(DIV_LSB, DIV_W);

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [SHIFT_W-1:0] shift;
        logic [DIV_W-1:0]   div;
    } cfg_t;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NBYTE-1:0] wr_strb,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output cfg_t             cfg
);
    typedef struct packed {
        logic [REG_W-1:0] word;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [REG_W-1:0] bmask;

    // byte strobes widened to a bit mask
    for (genvar b = 0; b < NBYTE; b++) begin : g_bmask
        assign bmask[b*8 +: 8] = {8{wr_strb[b]}};
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.word = ((st_q.word & ~bmask) | (wr_data & bmask)) & RW_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.word;
    assign cfg.sel   = st_q.word[SEL_LSB   +: SEL_W];
    assign cfg.shift = st_q.word[SHIFT_LSB +: SHIFT_W];
    assign cfg.div   = st_q.word[DIV_LSB   +: DIV_W];
endmodule

// File: rtl/clkdiv_pow2.sv
module clkdiv_pow2 #(
    parameter int SHIFT_W = 2,
    parameter int PRE_W   = (1 << SHIFT_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [SHIFT_W-1:0] shift,
    output logic               step,
    output logic [PRE_W-1:0]   cnt_next
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        // limit = 2^shift - 1 as a thermometer of ones
        for (int i = 0; i < PRE_W; i++) begin
            limit[i] = (i < int'(shift));
        end
        st_d = st_q;
        step = 1'b0;
        if (tick) begin
            if (st_q.cnt == limit) begin
                st_d.cnt = '0;
                step     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_next = st_d.cnt;
endmodule

// File: rtl/clkdiv_lin.sv
module clkdiv_lin #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [DIV_W-1:0] div,
    output logic             wrap,
    output logic [DIV_W-1:0] cnt_next
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } lin_st_t;

    lin_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (step) begin
            if (st_q.cnt == div) begin
                st_d.cnt = '0;
                wrap     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_next = st_d.cnt;
endmodule

// File: rtl/clkdiv_mux.sv
module clkdiv_mux
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_tick,
    input  logic             wr_en,
    input  logic [NBYTE-1:0] wr_strb,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             clk_en,
    output logic             clk_out
);
    localparam int RAT_W = POS_W + 1;

    typedef struct packed {
        cfg_t act;
        logic en;
        logic out;
    } top_st_t;

    top_st_t st_d, st_q;
    cfg_t cfg;
    logic [N_SRC-1:0] hit;
    logic tick_sel, pre_step, period_end;
    logic [PRE_W-1:0] pre_next;
    logic [DIV_W-1:0] lin_next;
    logic [RAT_W-1:0] ratio, half, pos;

    clkdiv_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_strb (wr_strb),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    // source selector from the active setting only
    for (genvar k = 0; k < N_SRC; k++) begin : g_sel
        assign hit[k] = src_tick[k] && (st_q.act.sel == SEL_W'(k));
    end
    assign tick_sel = |hit;

    clkdiv_pow2 #(.SHIFT_W(SHIFT_W), .PRE_W(PRE_W)) u_pow2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_sel),
        .shift    (st_q.act.shift),
        .step     (pre_step),
        .cnt_next (pre_next)
    );

    clkdiv_lin #(.DIV_W(DIV_W)) u_lin (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (pre_step),
        .div      (st_q.act.div),
        .wrap     (period_end),
        .cnt_next (lin_next)
    );

    always_comb begin
        st_d  = st_q;
        ratio = (RAT_W'(st_q.act.div) + RAT_W'(1)) << st_q.act.shift;
        half  = (ratio + RAT_W'(1)) >> 1;
        pos   = (RAT_W'(lin_next) << st_q.act.shift) | RAT_W'(pre_next);
        if (period_end) begin
            st_d.act = cfg;
        end
        st_d.en  = period_end;
        st_d.out = (pos < half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act <= '0;
            st_q.en  <= 1'b0;
            st_q.out <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_en  = st_q.en;
    assign clk_out = st_q.out;
endmodule

// File: rtl/clkdiv_mux_chk.sv
module clkdiv_mux_chk
    import clkdiv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [NBYTE-1:0] wr_strb,
    input logic [REG_W-1:0] rd_data,
    input logic             clk_en,
    input logic             clk_out,
    input logic             tick_sel,
    input logic             period_end,
    input cfg_t             act_q
);
    // R5
    ro_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~RW_MASK) == '0);

    // R6
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_strb == '0) |=> $stable(rd_data));

    // R7
    act_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(act_q));

    // R8
    en_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> $past(tick_sel));

    // R10
    en_with_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> clk_out);

    // R10
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> clk_en);
endmodule

bind clkdiv_mux clkdiv_mux_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_strb    (wr_strb),
    .rd_data    (rd_data),
    .clk_en     (clk_en),
    .clk_out    (clk_out),
    .tick_sel   (tick_sel),
    .period_end (period_end),
    .act_q      (st_q.act)
);

// File: tb/clkdiv_mux_tb.sv
module clkdiv_mux_tb;
    import clkdiv_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] src_tick = '0;
    logic             wr_en = 1'b0;
    logic [NBYTE-1:0] wr_strb = '0;
    logic [REG_W-1:0] wr_data = '0;
    logic [REG_W-1:0] rd_data;
    logic             clk_en, clk_out;

    clkdiv_mux u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .wr_en    (wr_en),
        .wr_strb  (wr_strb),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .clk_en   (clk_en),
        .clk_out  (clk_out)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    period;
        int    high;
        string tag;
    } exp_t;

    exp_t q[$];
    int   pp[N_SRC] = '{1, 2, 3, 5};
    int   ph[N_SRC] = '{0, 0, 0, 0};
    int   checks = 0, bad = 0;
    int   pulse_cnt = 0, last_t = 0, hi_cnt = 0, cyc = 0;
    bit   have_last = 0, prev_en = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // reference sources: source k pulses once every pp[k] system clocks
    initial forever begin
        @(negedge clk);
        for (int k = 0; k < N_SRC; k++) begin
            ph[k] = (ph[k] + 1) % pp[k];
            src_tick[k] = (ph[k] == 0);
        end
    end

    // monitor / scoreboard
    initial forever begin
        @(negedge clk);
        cyc++;
        if (rst_n && clk_en) begin
            if (have_last && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(cyc - last_t == e.period, e.tag, "period", cyc - last_t, e.period);
                check(hi_cnt == e.high, "R9", "high phase", hi_cnt, e.high);
                check(clk_out == 1'b1, "R10", "clk_out at pulse", int'(clk_out), 1);
                if (e.period > 1) check(!prev_en, "R8", "enable width", int'(prev_en), 0);
            end
            have_last = 1;
            last_t    = cyc;
            hi_cnt    = int'(clk_out);
            pulse_cnt++;
        end else begin
            hi_cnt += int'(clk_out);
        end
        prev_en = rst_n && clk_en;
    end

    function automatic logic [REG_W-1:0] mk(input int sel, input int s, input int n);
        return (REG_W'(sel) << SEL_LSB) | (REG_W'(s) << SHIFT_LSB) | (REG_W'(n) << DIV_LSB);
    endfunction

    task automatic wr(input logic [REG_W-1:0] d, input logic [NBYTE-1:0] s);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_strb = s;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0;
    endtask

    task automatic expect_n(input int sel, input int s, input int n, input int k,
                            input string tag);
        int c, nr;
        c  = pulse_cnt;
        wait (pulse_cnt >= c + 2);
        nr = (n + 1) << s;
        for (int i = 0; i < k; i++) q.push_back('{pp[sel] * nr, pp[sel] * ((nr + 1) / 2), tag});
        wait (pulse_cnt >= c + 2 + k);
    endtask

    task automatic run_cfg(input int sel, input int s, input int n, input int k,
                           input string tag);
        wr(mk(sel, s, n), '1);
        expect_n(sel, s, n, k, tag);
    endtask

    initial begin
        int c;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(rd_data == '0, "R1", "rd_data in reset", int'(rd_data), 0);
        check(clk_en == 1'b0, "R1", "clk_en in reset", int'(clk_en), 0);
        check(clk_out == 1'b1, "R1", "clk_out in reset", int'(clk_out), 1);
        rst_n = 1'b1;
        // R1: ratio 1 on source 0 after reset
        expect_n(0, 0, 0, 3, "R1");

        // R5 / R6: field readback and byte strobes
        wr('1, '1);
        @(negedge clk);
        check(rd_data == RW_MASK, "R5", "all ones readback", int'(rd_data), int'(RW_MASK));
        wr('0, 4'b0010);
        @(negedge clk);
        check(rd_data == 32'h0003_0030, "R6", "clear divisor byte", int'(rd_data), 32'h0003_0030);
        wr('0, 4'b0100);
        @(negedge clk);
        check(rd_data == 32'h0000_0030, "R6", "clear select byte", int'(rd_data), 32'h30);
        wr('1, 4'b0000);
        @(negedge clk);
        check(rd_data == 32'h0000_0030, "R6", "no strobe write", int'(rd_data), 32'h30);
        wr(32'h0002_0A20, 4'b1111);
        @(negedge clk);
        check(rd_data == 32'h0002_0A20, "R5", "mixed readback", int'(rd_data), 32'h0002_0A20);

        // R3 / R4: every exponent at several divisors on source 1
        for (int s = 0; s < 4; s++) begin
            run_cfg(1, s, 0, 2, "R3");
            run_cfg(1, s, 1, 2, "R4");
            run_cfg(1, s, 6, 2, "R4");
            run_cfg(1, s, 31, 2, "R4");
        end

        // R2: other sources
        run_cfg(0, 1, 2, 2, "R2");
        run_cfg(2, 1, 2, 2, "R2");
        run_cfg(3, 1, 2, 2, "R2");
        run_cfg(3, 0, 4, 2, "R2");

        // R7: write in mid-period keeps the old ratio for that period
        run_cfg(0, 0, 19, 1, "R4");
        c = pulse_cnt;
        wait (pulse_cnt >= c + 1);
        q.push_back('{20, 10, "R7"});
        q.push_back('{4, 2, "R7"});
        repeat (5) @(negedge clk);
        wr(mk(0, 0, 3), '1);
        wait (pulse_cnt >= c + 3);
        check(q.size() == 0, "R7", "queue drained", q.size(), 0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule